// File: doc/BRIEF.md
# Nonlinear-Gain Biquad Loop Compensator

This block is the fixed-point compensator of a voltage-mode converter control loop. A strobe delivers one signed error sample per control cycle. The sample first passes a gain stage: the error magnitude selects one of four bands, and each band has its own gain. Band selection can be switched off, and then only the base gain is applied. The scaled error then drives a second-order IIR section with programmable feed-forward and feedback coefficients. The result is clamped to the duty-command range and handed to a PWM unit with a one-cycle valid pulse.

There are two complete parameter sets, one for soft-start and one for normal regulation. A select input picks the set, and its value is latched when a sample is accepted. The filter history is common to both sets, so a change of set takes effect without a jump in state. One shared multiplier computes the whole update. Because of that, the result appears a fixed number of cycles after the strobe, and strobes that arrive during that time are dropped.

Top module: `loop_comp`

## Requirements
- R1: The output is floor(acc / 2^14) with acc = b0·s0 + b1·s1 + b2·s2 − a1·y1 − a2·y2. Coefficients are signed Q2.14 fields of CW bits packed in a coefficient port: slot 0 b0, slot 1 b1, slot 2 b2, slot 3 a1, slot 4 a2, slot k at bits k·CW.
- R2: With band selection enabled, the gain is band 0 for |e| ≤ lim0, band 1 for lim0 < |e| ≤ lim1, band 2 for lim1 < |e| ≤ lim2, and band 3 above lim2. A magnitude equal to a threshold takes the lower band. Threshold i is an unsigned EW-bit field at bits i·EW, and gain i is a GW-bit field at bits i·GW. Thresholds are programmed in ascending order.
- R3: Gains are unsigned with GW−2 fractional bits (Q2.6 by default). The scaled error is s0 = floor(e·g / 2^(GW−2)). With the enable bit low, g is always gain 0, whatever the thresholds and other gains are.
- R4: bank_sel = 0 selects the soft-start set and bank_sel = 1 selects the normal set. The value is taken when a strobe is accepted. A change of bank_sel while that sample is being computed has no effect on its result.
- R5: The result is clamped to 0 … 2^DW − 1. The clamped value is the one stored as the y history.
- R6: The history (s1, s2, y1, y2) is shared by both sets and is kept across changes of set. Reset clears all of it to zero.
- R7: A strobe accepted on a rising edge gives out_valid high for the cycle that follows the 7th rising edge after it, and not earlier.
- R8: out_valid is high for exactly one cycle per accepted sample. duty changes only together with out_valid and holds its value in between.
- R9: A strobe that arrives during the 7 cycles after an acceptance is ignored. It produces no output and does not advance the history.
- R10: While reset is asserted and after it is released, out_valid is 0 and duty is 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Error sample strobe |
| err | input | EW | Signed error sample |
| bank_sel | input | 1 | Parameter set select, 0 soft-start, 1 normal |
| ss_coef | input | 5·CW | Soft-start filter coefficients |
| ss_lim | input | 3·EW | Soft-start band thresholds |
| ss_gain | input | 4·GW | Soft-start band gains |
| ss_nl_en | input | 1 | Soft-start band selection enable |
| nm_coef | input | 5·CW | Normal filter coefficients |
| nm_lim | input | 3·EW | Normal band thresholds |
| nm_gain | input | 4·GW | Normal band gains |
| nm_nl_en | input | 1 | Normal band selection enable |
| out_valid | output | 1 | Duty command valid pulse |
| duty | output | DW | Clamped duty command |

## Verification
The bench builds the block with a 6-bit error and an 8-bit duty command, and keeps the 16-bit coefficients and 8-bit gains. At that size every one of the 64 error codes can be swept under each configuration, so every threshold equality, the most negative error and both clamp edges are all reached. The sweeps run with an identity filter, with a full biquad and four gain bands, with a high-gain set that drives the top clamp, and with the two sets alternating from sample to sample. Further runs flip the set select during a computation, send extra strobes while the block is busy, and reset the block mid-stream, so the history rules are seen through later outputs.

// File: rtl/loop_comp.sv
module loop_comp #(
  parameter int EW = 12,
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int GW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EW-1:0]     err,
  input  logic              bank_sel,
  input  logic [5*CW-1:0]   ss_coef,
  input  logic [3*EW-1:0]   ss_lim,
  input  logic [4*GW-1:0]   ss_gain,
  input  logic              ss_nl_en,
  input  logic [5*CW-1:0]   nm_coef,
  input  logic [3*EW-1:0]   nm_lim,
  input  logic [4*GW-1:0]   nm_gain,
  input  logic              nm_nl_en,
  output logic              out_valid,
  output logic [DW-1:0]     duty
);
  localparam int CF = CW - 2;
  localparam int GF = GW - 2;
  localparam int SW = EW + 2;
  localparam int XW = (SW > DW + 1) ? SW : DW + 1;
  localparam int PW = CW + XW;
  localparam int AW = PW + 3;
  localparam logic signed [AW-1:0] DMAX = {{(AW-DW){1'b0}}, {DW{1'b1}}};

  logic [2:0]              ph;
  logic                    busy;
  logic                    bank_q;
  logic signed [EW-1:0]    e_in;
  logic signed [SW-1:0]    e0, e1, e2;
  logic [DW-1:0]           y1, y2;
  logic signed [AW-1:0]    acc;

  logic [5*CW-1:0]         cset;
  logic [3*EW-1:0]         lset;
  logic [4*GW-1:0]         gset;
  logic                    nlen;

  assign busy = (ph != 3'd0);
  assign cset = bank_q ? nm_coef  : ss_coef;
  assign lset = bank_q ? nm_lim   : ss_lim;
  assign gset = bank_q ? nm_gain  : ss_gain;
  assign nlen = bank_q ? nm_nl_en : ss_nl_en;

  logic signed [EW:0] ex;
  logic [EW:0]        mag;
  logic [GW-1:0]      gsel;

  assign ex  = {e_in[EW-1], e_in};
  assign mag = ex[EW] ? $unsigned(-ex) : $unsigned(ex);

  always_comb begin
    gsel = gset[0 +: GW];
    if (nlen) begin
      if (mag > {1'b0, lset[0 +: EW]})    gsel = gset[GW +: GW];
      if (mag > {1'b0, lset[EW +: EW]})   gsel = gset[2*GW +: GW];
      if (mag > {1'b0, lset[2*EW +: EW]}) gsel = gset[3*GW +: GW];
    end
  end

  logic signed [CW-1:0] ma;
  logic signed [XW-1:0] mb;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prodx;
  logic signed [SW-1:0] scl;
  logic signed [AW-1:0] q;
  logic [DW-1:0]        ysat;

  always_comb begin
    ma = cset[0 +: CW];
    mb = XW'(e0);
    case (ph)
      3'd1: begin ma = CW'(gsel);          mb = XW'(e_in); end
      3'd3: begin ma = cset[CW +: CW];     mb = XW'(e1);   end
      3'd4: begin ma = cset[2*CW +: CW];   mb = XW'(e2);   end
      3'd5: begin ma = cset[3*CW +: CW];   mb = XW'(y1);   end
      3'd6: begin ma = cset[4*CW +: CW];   mb = XW'(y2);   end
      default: ;
    endcase
  end

  assign prod  = ma * mb;
  assign prodx = AW'(prod);
  assign scl   = SW'(prod >>> GF);
  assign q     = acc >>> CF;

  always_comb begin
    if (q < 0)         ysat = '0;
    else if (q > DMAX) ysat = '1;
    else               ysat = q[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= '0;
      bank_q    <= 1'b0;
      e_in      <= '0;
      e0        <= '0;
      e1        <= '0;
      e2        <= '0;
      y1        <= '0;
      y2        <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      duty      <= '0;
    end else begin
      out_valid <= 1'b0;
      case (ph)
        3'd0: if (in_valid) begin
          e_in   <= err;
          bank_q <= bank_sel;
          ph     <= 3'd1;
        end
        3'd1: begin
          e0 <= scl;
          ph <= 3'd2;
        end
        3'd2: begin
          acc <= prodx;
          ph  <= 3'd3;
        end
        3'd3, 3'd4: begin
          acc <= acc + prodx;
          ph  <= ph + 3'd1;
        end
        3'd5, 3'd6: begin
          acc <= acc - prodx;
          ph  <= ph + 3'd1;
        end
        default: begin
          out_valid <= 1'b1;
          duty      <= ysat;
          e2        <= e1;
          e1        <= e0;
          y2        <= y1;
          y1        <= ysat;
          ph        <= 3'd0;
        end
      endcase
    end
  end
endmodule

module loop_comp_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          busy,
  input logic          out_valid,
  input logic [DW-1:0] duty
);
  // R7
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |-> ##8 out_valid);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(duty));

  // R9
  result_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));

  // R9
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> !busy);
endmodule

bind loop_comp loop_comp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .duty(duty)
);

// File: tb/loop_comp_bench.sv
`timescale 1ns/1ps
module loop_comp_bench;
  localparam int EW = 6;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int GW = 8;
  localparam int YMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [EW-1:0] err;
  logic bank_sel;
  logic [5*CW-1:0] ss_coef, nm_coef;
  logic [3*EW-1:0] ss_lim, nm_lim;
  logic [4*GW-1:0] ss_gain, nm_gain;
  logic out_valid;
  logic [DW-1:0] duty;

  int cc[2][5];
  int ll[2][3];
  int gg[2][4];
  bit nl[2];
  int he1, he2, hy1, hy2;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 5; k++) begin
      ss_coef[k*CW +: CW] = CW'(cc[0][k]);
      nm_coef[k*CW +: CW] = CW'(cc[1][k]);
    end
    for (int k = 0; k < 3; k++) begin
      ss_lim[k*EW +: EW] = EW'(ll[0][k]);
      nm_lim[k*EW +: EW] = EW'(ll[1][k]);
    end
    for (int k = 0; k < 4; k++) begin
      ss_gain[k*GW +: GW] = GW'(gg[0][k]);
      nm_gain[k*GW +: GW] = GW'(gg[1][k]);
    end
  end

  loop_comp #(.EW(EW), .DW(DW), .CW(CW), .GW(GW)) u_loop_comp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .err(err), .bank_sel(bank_sel),
    .ss_coef(ss_coef), .ss_lim(ss_lim), .ss_gain(ss_gain), .ss_nl_en(nl[0]),
    .nm_coef(nm_coef), .nm_lim(nm_lim), .nm_gain(nm_gain), .nm_nl_en(nl[1]),
    .out_valid(out_valid), .duty(duty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic sample(input int e, input int b, input bit flip, input bit dup, input string tag);
    int mag, g, s, y;
    longint acc, q;
    bit seen;
    mag = (e < 0) ? -e : e;
    if (!nl[b] || mag <= ll[b][0]) g = gg[b][0];
    else if (mag <= ll[b][1])      g = gg[b][1];
    else if (mag <= ll[b][2])      g = gg[b][2];
    else                           g = gg[b][3];
    s = (e * g) >>> 6;
    acc = longint'(cc[b][0]) * s + longint'(cc[b][1]) * he1 + longint'(cc[b][2]) * he2
        - longint'(cc[b][3]) * hy1 - longint'(cc[b][4]) * hy2;
    q = acc >>> 14;
    y = (q < 0) ? 0 : ((q > YMAX) ? YMAX : int'(q));

    @(negedge clk);
    err = EW'(e);
    bank_sel = b[0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (flip) bank_sel = ~b[0];
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (dup && i == 2) in_valid = 1'b1;
      if (dup && i == 3) in_valid = 1'b0;
      if (i == 6) chk(out_valid == 1'b0, "R7 early", int'(out_valid), 0);
    end
    chk(out_valid == 1'b1, "R7 valid", int'(out_valid), 1);
    chk(int'(duty) == y, tag, int'(duty), y);
    @(negedge clk);
    chk(out_valid == 1'b0 && int'(duty) == y, "R8 hold", int'(duty), y);
    if (dup) begin
      seen = 1'b0;
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      chk(!seen, "R9 extra", int'(seen), 0);
    end
    bank_sel = b[0];
    he2 = he1; he1 = s; hy2 = hy1; hy1 = y;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; err = '0; bank_sel = 1'b0;
    he1 = 0; he2 = 0; hy1 = 0; hy2 = 0;
    cc[0] = '{16384, 0, 0, 0, 0};
    ll[0] = '{4, 10, 20};
    gg[0] = '{64, 64, 64, 64};
    nl[0] = 1'b0;
    cc[1] = '{16000, 4000, -2000, -8000, 1000};
    ll[1] = '{1, 2, 3};
    gg[1] = '{32, 200, 250, 255};
    nl[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && duty == '0, "R10 in reset", int'(duty), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && duty == '0, "R10 released", int'(duty), 0);

    for (int e = -32; e < 32; e++) sample(e, 0, 1'b0, 1'b0, "R1 identity/R5 low clamp");

    cc[0] = '{20000, -8000, 3000, -12000, 2000};
    gg[0] = '{32, 64, 96, 160};
    nl[0] = 1'b1;
    for (int e = -32; e < 32; e++) sample(e, 0, 1'b0, 1'b0, "R2 bands up");
    for (int e = 31; e >= -32; e--) sample(e, 0, 1'b0, 1'b0, "R2 bands down");

    nl[0] = 1'b0;
    for (int e = -32; e < 32; e++) sample(e, 0, 1'b0, 1'b0, "R3 base gain only");

    cc[0] = '{32767, 0, 0, -12000, 0};
    gg[0] = '{255, 255, 255, 255};
    for (int e = 0; e < 32; e++) sample(e, 0, 1'b0, 1'b0, "R5 high clamp");

    cc[0] = '{20000, -8000, 3000, -12000, 2000};
    gg[0] = '{32, 64, 96, 160};
    nl[0] = 1'b1;
    for (int e = -32; e < 32; e++) sample(e, e & 1, 1'b0, 1'b0, "R6 shared history/R3 bank1");

    for (int e = -20; e < 20; e += 3) sample(e, (e + 32) & 1, 1'b1, 1'b0, "R4 select latched");

    for (int e = -30; e < 30; e += 7) sample(e, 0, 1'b0, 1'b1, "R9 busy strobe");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && duty == '0, "R10 mid reset", int'(duty), 0);
    rst_n = 1'b1;
    he1 = 0; he2 = 0; hy1 = 0; hy2 = 0;
    for (int e = 31; e > 10; e -= 4) sample(e, 1, 1'b0, 1'b0, "R6 reset clears history");

    summary();
    $finish;
  end
endmodule